// File: doc/BRIEF.md
# Filtered event counter bank

This block holds a small set of event counters for an accelerator's performance monitor. Event sources arrive as single-cycle pulses on a number of parallel ports. Each pulse carries an event category, an event code and a tag of attributes: work-queue index, traffic class, page-size class, transfer-size class and engine index. Every counter is told which category and code it should count. Five per-counter mask registers can then narrow that down to events whose attributes fall into chosen sets. A counter that sees several matching pulses in one cycle adds all of them.

Software reaches the bank through a simple word-wide register port. It can read a fixed capability word pair. It can freeze and unfreeze every counter at once. It can issue reset commands that wipe either the configuration or the counted values. It can inspect and acknowledge per-counter wrap flags. Counters are narrower than the bus and wrap at their programmed width. A wrap latches a sticky flag, and a flag whose counter has its interrupt bit set drives the interrupt line.

Top module: `evcnt_bank`

## Requirements
- R1: After reset, every counter value, configuration word and filter mask reads 0, the freeze register reads 0, the wrap status reads 0 and `irq` is low.
- R2: Address 0x00 reads the capability word. Bits [7:0] hold the counter count, [15:8] the counter width, [20:16] the number of supported categories, and bit 21 and bit 22 read 1 (wrap interrupt and freeze are present). Bit 23 reads 0 (no per-counter capabilities), and [28:24] hold the supported-filter bitmap. Address 0x01 reads the supported-category bitmap in [15:0]. Writes to either address change nothing.
- R3: Counter i lives at 0x10+8*i. Offset 0 is its config word: bit 0 enable, bit 1 wrap-interrupt enable, [7:4] category, [8+CODE_W-1:8] code. Offset 1 is its value. An enabled, unfrozen counter adds the number of ports that carry a valid event of exactly its category and code, and that pass every filter, in that cycle. A read returns its data with `reg_rvalid` one cycle after `reg_rd`.
- R4: Filter offsets are 2 work queue (32-bit mask), 3 traffic class (8-bit), 4 page size (4-bit), 5 transfer size (8-bit) and 6 engine (8-bit). The attribute tag of a port is {wq[4:0], tc[2:0], pg[1:0], xs[2:0], eng[2:0]}, most significant first. A mask of zero passes every event. A nonzero mask passes an event only when the bit indexed by that attribute is set.
- R5: A filter whose bit in the supported-filter bitmap (bit 0 wq, 1 tc, 2 pg, 3 xs, 4 eng) is clear reads 0, ignores writes and passes every event.
- R6: Writing 1 to bit 0 of address 0x02 freezes every counter, keeping its value. Writing 0 resumes counting. The register reads back its state.
- R7: Clearing a counter's enable bit stops it and keeps its value.
- R8: A write to address 0x03 with bit 0 set clears every config word and filter mask. With bit 1 set it zeroes every counter value. Each command leaves the other kind of state alone.
- R9: A counter wraps modulo 2^CNT_W and sets its bit in the wrap status at address 0x04 in the same clock edge.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it. A bit that is already set stays set on a further wrap, and a wrap in the cycle of a clear leaves the bit set.
- R11: `irq` goes high one cycle after a status bit is set for a counter whose interrupt enable is set, and it goes low one cycle after no such bit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| ev_valid | input | EV_PORTS | Event pulse per port |
| ev_cat | input | 4*EV_PORTS | Event category per port |
| ev_code | input | CODE_W*EV_PORTS | Event code per port |
| ev_attr | input | 16*EV_PORTS | Attribute tag per port |
| irq | output | 1 | Wrap interrupt, registered |

## Verification
A corrupted filter or match path shows up at the value register of one counter on the next read after the offending pulse. The stimulus table therefore re-reads three differently filtered counters after every single event. A lost or late wrap flag shows at the status word in the cycle after the wrap and at `irq` one cycle later. Both are sampled on those exact cycles. A freeze or reset command that reaches the wrong state is caught by reading the value and the config word back immediately after the command.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CAT_W  = 4;
  localparam int ATTR_W = 16;

  localparam logic [ADDR_W-1:0] A_CAP0 = 8'h00;
  localparam logic [ADDR_W-1:0] A_CAP1 = 8'h01;
  localparam logic [ADDR_W-1:0] A_FRZ  = 8'h02;
  localparam logic [ADDR_W-1:0] A_RST  = 8'h03;
  localparam logic [ADDR_W-1:0] A_OVF  = 8'h04;
  localparam int SLOT_BLK0 = 2;

  localparam logic [2:0] F_CFG  = 3'd0;
  localparam logic [2:0] F_DATA = 3'd1;
  localparam logic [2:0] F_WQ   = 3'd2;
  localparam logic [2:0] F_TC   = 3'd3;
  localparam logic [2:0] F_PG   = 3'd4;
  localparam logic [2:0] F_XS   = 3'd5;
  localparam logic [2:0] F_EG   = 3'd6;

  localparam int FB_WQ = 0;
  localparam int FB_TC = 1;
  localparam int FB_PG = 2;
  localparam int FB_XS = 3;
  localparam int FB_EG = 4;

  localparam int CFG_EN_B   = 0;
  localparam int CFG_IEN_B  = 1;
  localparam int CFG_CAT_LO = 4;
  localparam int CFG_CODE_LO = 8;

  typedef struct packed {
    logic [4:0] wq;
    logic [2:0] tc;
    logic [1:0] pg;
    logic [2:0] xs;
    logic [2:0] eng;
  } ev_attr_t;

  typedef struct packed {
    logic [31:0] wq;
    logic [7:0]  tc;
    logic [3:0]  pg;
    logic [7:0]  xs;
    logic [7:0]  eng;
  } flt_t;

  function automatic int popcount16(input logic [15:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/evcnt_match.sv
module evcnt_match
  import evcnt_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              ev_valid,
  input  logic [CAT_W-1:0]  ev_cat,
  input  logic [CODE_W-1:0] ev_code,
  input  ev_attr_t          ev_attr,
  input  logic [CAT_W-1:0]  sel_cat,
  input  logic [CODE_W-1:0] sel_code,
  input  flt_t              flt,
  output logic              hit
);

  logic wq_ok, tc_ok, pg_ok, xs_ok, eg_ok, id_ok;

  always_comb begin
    wq_ok = (flt.wq  == '0) || flt.wq[ev_attr.wq];
    tc_ok = (flt.tc  == '0) || flt.tc[ev_attr.tc];
    pg_ok = (flt.pg  == '0) || flt.pg[ev_attr.pg];
    xs_ok = (flt.xs  == '0) || flt.xs[ev_attr.xs];
    eg_ok = (flt.eng == '0) || flt.eng[ev_attr.eng];
    id_ok = (ev_cat == sel_cat) && (ev_code == sel_code);
    hit   = ev_valid && id_ok && wq_ok && tc_ok && pg_ok && xs_ok && eg_ok;
  end

endmodule

// File: rtl/evcnt_slot.sv
module evcnt_slot
  import evcnt_pkg::*;
#(
  parameter int         CNT_W    = 12,
  parameter int         CODE_W   = 16,
  parameter int         EV_PORTS = 2,
  parameter logic [4:0] FLT_SUP  = 5'b11011
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_clr,
  input  logic                       val_clr,
  input  logic                       frozen,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_field,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [EV_PORTS-1:0]        ev_valid,
  input  logic [EV_PORTS*CAT_W-1:0]  ev_cat,
  input  logic [EV_PORTS*CODE_W-1:0] ev_code,
  input  logic [EV_PORTS*ATTR_W-1:0] ev_attr,
  output logic [DATA_W-1:0]          cfg_word,
  output logic [CNT_W-1:0]           cnt,
  output flt_t                       flt,
  output logic                       ien,
  output logic                       wrap
);

  localparam int INC_W = $clog2(EV_PORTS + 1);

  logic              en_q, ien_q;
  logic [CAT_W-1:0]  cat_q;
  logic [CODE_W-1:0] code_q;
  flt_t              flt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EV_PORTS-1:0] hits;
  logic [INC_W-1:0]  inc;
  logic [CNT_W:0]    sum;
  logic              active;

  // configuration and filter storage
  always_ff @(posedge clk) begin
    if (rst || cfg_clr) begin
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
      cat_q  <= '0;
      code_q <= '0;
      flt_q  <= '0;
    end else if (wr_en) begin
      case (wr_field)
        F_CFG: begin
          en_q   <= wdata[CFG_EN_B];
          ien_q  <= wdata[CFG_IEN_B];
          cat_q  <= wdata[CFG_CAT_LO +: CAT_W];
          code_q <= wdata[CFG_CODE_LO +: CODE_W];
        end
        F_WQ: if (FLT_SUP[FB_WQ]) flt_q.wq  <= wdata;
        F_TC: if (FLT_SUP[FB_TC]) flt_q.tc  <= wdata[7:0];
        F_PG: if (FLT_SUP[FB_PG]) flt_q.pg  <= wdata[3:0];
        F_XS: if (FLT_SUP[FB_XS]) flt_q.xs  <= wdata[7:0];
        F_EG: if (FLT_SUP[FB_EG]) flt_q.eng <= wdata[7:0];
        default: ;
      endcase
    end
  end

  // one matcher per event port
  for (genvar p = 0; p < EV_PORTS; p++) begin : g_port
    evcnt_match #(.CODE_W(CODE_W)) u_match (
      .ev_valid (ev_valid[p]),
      .ev_cat   (ev_cat[p*CAT_W +: CAT_W]),
      .ev_code  (ev_code[p*CODE_W +: CODE_W]),
      .ev_attr  (ev_attr_t'(ev_attr[p*ATTR_W +: ATTR_W])),
      .sel_cat  (cat_q),
      .sel_code (code_q),
      .flt      (flt_q),
      .hit      (hits[p])
    );
  end

  always_comb begin
    inc = '0;
    for (int p = 0; p < EV_PORTS; p++) inc = inc + INC_W'(hits[p]);
    sum    = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
    active = en_q && !frozen;
  end

  always_ff @(posedge clk) begin
    if (rst || val_clr) cnt_q <= '0;
    else if (active)    cnt_q <= sum[CNT_W-1:0];
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_EN_B]  = en_q;
    cfg_word[CFG_IEN_B] = ien_q;
    cfg_word[CFG_CAT_LO +: CAT_W]   = cat_q;
    cfg_word[CFG_CODE_LO +: CODE_W] = code_q;
  end

  assign cnt  = cnt_q;
  assign flt  = flt_q;
  assign ien  = ien_q;
  assign wrap = active && sum[CNT_W] && !val_clr;

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int          NUM_CNT  = 4,
  parameter int          CNT_W    = 12,
  parameter int          CODE_W   = 16,
  parameter int          EV_PORTS = 2,
  parameter logic [4:0]  FLT_SUP  = 5'b11011,
  parameter logic [15:0] CAT_SUP  = 16'h00FF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [7:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       reg_rvalid,
  input  logic [EV_PORTS-1:0]        ev_valid,
  input  logic [EV_PORTS*4-1:0]      ev_cat,
  input  logic [EV_PORTS*CODE_W-1:0] ev_code,
  input  logic [EV_PORTS*16-1:0]     ev_attr,
  output logic                       irq
);

  localparam int NUM_CAT = popcount16(CAT_SUP);
  localparam logic [DATA_W-1:0] CAP0_VAL = {3'b000, FLT_SUP, 1'b0, 1'b1, 1'b1,
                                            5'(NUM_CAT), 8'(CNT_W), 8'(NUM_CNT)};
  localparam logic [DATA_W-1:0] CAP1_VAL = {16'h0000, CAT_SUP};

  logic               frz_q;
  logic [NUM_CNT-1:0] ovf_q;
  logic               irq_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;

  logic               rst_cmd, cfg_clr, val_clr;
  logic [NUM_CNT-1:0] w1c, slot_sel, ien_v, wrap_v;
  logic [DATA_W-1:0]  cfg_w [NUM_CNT];
  logic [CNT_W-1:0]   cnt_v [NUM_CNT];
  flt_t               flt_v [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_all;
  logic [DATA_W-1:0]  rd_word;

  assign rst_cmd = reg_wr && (reg_addr == A_RST);
  assign cfg_clr = rst_cmd && reg_wdata[0];
  assign val_clr = rst_cmd && reg_wdata[1];
  assign w1c     = (reg_wr && (reg_addr == A_OVF)) ? reg_wdata[NUM_CNT-1:0] : '0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    assign slot_sel[i] = (reg_addr[7:3] == 5'(SLOT_BLK0 + i));
    assign cnt_all[i*CNT_W +: CNT_W] = cnt_v[i];

    evcnt_slot #(
      .CNT_W(CNT_W), .CODE_W(CODE_W), .EV_PORTS(EV_PORTS), .FLT_SUP(FLT_SUP)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .cfg_clr  (cfg_clr),
      .val_clr  (val_clr),
      .frozen   (frz_q),
      .wr_en    (reg_wr && slot_sel[i]),
      .wr_field (reg_addr[2:0]),
      .wdata    (reg_wdata),
      .ev_valid (ev_valid),
      .ev_cat   (ev_cat),
      .ev_code  (ev_code),
      .ev_attr  (ev_attr),
      .cfg_word (cfg_w[i]),
      .cnt      (cnt_v[i]),
      .flt      (flt_v[i]),
      .ien      (ien_v[i]),
      .wrap     (wrap_v[i])
    );
  end

  // global freeze, sticky wrap status, interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q <= 1'b0;
      ovf_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (reg_wr && (reg_addr == A_FRZ)) frz_q <= reg_wdata[0];
      ovf_q <= (ovf_q & ~w1c) | wrap_v;
      irq_q <= |(ovf_q & ien_v);
    end
  end

  // read multiplexer
  always_comb begin
    rd_word = '0;
    case (reg_addr)
      A_CAP0: rd_word = CAP0_VAL;
      A_CAP1: rd_word = CAP1_VAL;
      A_FRZ:  rd_word = {31'b0, frz_q};
      A_OVF:  rd_word = {{(DATA_W - NUM_CNT){1'b0}}, ovf_q};
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (slot_sel[i]) begin
            case (reg_addr[2:0])
              F_CFG:  rd_word = cfg_w[i];
              F_DATA: rd_word = {{(DATA_W - CNT_W){1'b0}}, cnt_v[i]};
              F_WQ:   rd_word = flt_v[i].wq;
              F_TC:   rd_word = {24'b0, flt_v[i].tc};
              F_PG:   rd_word = {28'b0, flt_v[i].pg};
              F_XS:   rd_word = {24'b0, flt_v[i].xs};
              F_EG:   rd_word = {24'b0, flt_v[i].eng};
              default: rd_word = '0;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rd_word;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
  assign irq        = irq_q;

endmodule

// File: rtl/evcnt_bank_chk.sv
module evcnt_bank_chk #(
  parameter int NUM_CNT  = 4,
  parameter int CNT_W    = 12,
  parameter int EV_PORTS = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_wr,
  input logic [7:0]               reg_addr,
  input logic [31:0]              reg_wdata,
  input logic                     frz_q,
  input logic [NUM_CNT-1:0]       ovf_q,
  input logic [NUM_CNT-1:0]       ien_v,
  input logic [NUM_CNT*CNT_W-1:0] cnt_all,
  input logic                     irq
);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && (ovf_q == '0) && !frz_q)); // R1

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !(reg_wr && reg_addr == 8'h03)) |=> $stable(cnt_all)); // R6

  AST_VALUE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h03 && reg_wdata[1]) |=> (cnt_all == '0)); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 8'h04) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ovf_q == '0) |=> !irq); // R11

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien_v != '0)); // R11

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_wrap
    AST_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf_q[i]) |-> (cnt_all[i*CNT_W +: CNT_W] < CNT_W'(EV_PORTS))); // R9
  end

endmodule

bind evcnt_bank evcnt_bank_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EV_PORTS(EV_PORTS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .frz_q     (frz_q),
  .ovf_q     (ovf_q),
  .ien_v     (ien_v),
  .cnt_all   (cnt_all),
  .irq       (irq)
);

// File: tb/evcnt_bank_test.sv
module evcnt_bank_test;

  localparam int EVP = 2;
  localparam int CW  = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            reg_rvalid;
  logic [EVP-1:0]  ev_valid = '0;
  logic [EVP*4-1:0]  ev_cat = '0;
  logic [EVP*CW-1:0] ev_code = '0;
  logic [EVP*16-1:0] ev_attr = '0;
  logic            irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evcnt_bank uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ev_valid(ev_valid), .ev_cat(ev_cat), .ev_code(ev_code), .ev_attr(ev_attr),
    .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  cat;
    logic [15:0] code;
    logic [4:0]  wq;
    logic [2:0]  tc;
    logic [1:0]  pg;
    logic        e0, e1, e2;
  } vec_t;

  // counter0: cat3/A5, tc mask 0x06; counter1: cat3/A5, wq mask bit7, pg mask (unsupported);
  // counter2: cat5/11 unfiltered
  localparam vec_t VEC [0:7] = '{
    '{4'd3, 16'h00A5, 5'd7,  3'd1, 2'd3, 1'b1, 1'b1, 1'b0},
    '{4'd3, 16'h00A5, 5'd7,  3'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    '{4'd3, 16'h00A5, 5'd3,  3'd2, 2'd1, 1'b1, 1'b0, 1'b0},
    '{4'd3, 16'h00A4, 5'd7,  3'd2, 2'd0, 1'b0, 1'b0, 1'b0},
    '{4'd2, 16'h00A5, 5'd7,  3'd1, 2'd0, 1'b0, 1'b0, 1'b0},
    '{4'd5, 16'h0011, 5'd0,  3'd0, 2'd2, 1'b0, 1'b0, 1'b1},
    '{4'd3, 16'h00A5, 5'd7,  3'd2, 2'd0, 1'b1, 1'b1, 1'b0},
    '{4'd5, 16'h0011, 5'd31, 3'd7, 2'd3, 1'b0, 1'b0, 1'b1}
  };

  function automatic logic [7:0] sa(input int slot, input int fld);
    return 8'(8'h10 + 8 * slot + fld);
  endfunction

  function automatic logic [31:0] cfgw(input logic [3:0] cat, input logic [15:0] code,
                                       input logic en, input logic ie);
    return {8'h00, code, cat, 2'b00, ie, en};
  endfunction

  function automatic logic [15:0] mk_attr(input logic [4:0] wq, input logic [2:0] tc,
                                          input logic [1:0] pg);
    return {wq, tc, pg, 3'd0, 3'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    v = reg_rvalid;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    rd(a, d, v);
    chk(tag, d, exp);
  endtask

  task automatic set_ev(input logic [EVP-1:0] m, input logic [3:0] cat,
                        input logic [15:0] code, input logic [15:0] at);
    ev_valid = m;
    ev_cat   = {EVP{cat}};
    ev_code  = {EVP{code}};
    ev_attr  = {EVP{at}};
  endtask

  task automatic pulse(input logic [EVP-1:0] m, input logic [3:0] cat,
                       input logic [15:0] code, input logic [15:0] at);
    @(negedge clk);
    set_ev(m, cat, code, at);
    @(negedge clk);
    ev_valid = '0;
  endtask

  task automatic stream(input int cycles);
    @(negedge clk);
    set_ev(2'b11, 4'd1, 16'h0001, 16'h0000);
    repeat (cycles) @(negedge clk);
    ev_valid = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e0, e1, e2;
    logic [31:0] d;
    logic v;
    e0 = 0; e1 = 0; e2 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rchk("R1 status", 8'h04, 0);
    rchk("R1 freeze", 8'h02, 0);
    rchk("R1 value", sa(0, 1), 0);
    rchk("R1 config", sa(1, 0), 0);
    rchk("R1 filter", sa(0, 3), 0);

    // R2 capability words, read only
    rchk("R2 cap0", 8'h00, 32'h1B68_0C04);
    rchk("R2 cap1", 8'h01, 32'h0000_00FF);
    wr(8'h00, 32'h0);
    wr(8'h01, 32'hFFFF_FFFF);
    rchk("R2 cap0 after write", 8'h00, 32'h1B68_0C04);
    rchk("R2 cap1 after write", 8'h01, 32'h0000_00FF);

    // setup
    wr(sa(0, 0), cfgw(4'd3, 16'h00A5, 1'b1, 1'b0));
    wr(sa(0, 3), 32'h06);
    wr(sa(1, 0), cfgw(4'd3, 16'h00A5, 1'b1, 1'b0));
    wr(sa(1, 2), 32'h80);
    wr(sa(1, 4), 32'h1);
    wr(sa(2, 0), cfgw(4'd5, 16'h0011, 1'b1, 1'b0));
    rchk("R4 tc mask readback", sa(0, 3), 32'h06);
    rchk("R5 unsupported page-size mask", sa(1, 4), 0);
    rd(sa(0, 0), d, v);
    chk("R3 config readback", d, cfgw(4'd3, 16'h00A5, 1'b1, 1'b0));
    chk("R3 read valid", 32'(v), 1);

    // table walk: R3 match, R4 filters, R5 ignored filter
    for (int k = 0; k < 8; k++) begin
      pulse(2'b01, VEC[k].cat, VEC[k].code, mk_attr(VEC[k].wq, VEC[k].tc, VEC[k].pg));
      e0 += int'(VEC[k].e0);
      e1 += int'(VEC[k].e1);
      e2 += int'(VEC[k].e2);
      rchk($sformatf("R4 row %0d counter0", k), sa(0, 1), 32'(e0));
      rchk($sformatf("R5 row %0d counter1", k), sa(1, 1), 32'(e1));
      rchk($sformatf("R3 row %0d counter2", k), sa(2, 1), 32'(e2));
    end
    rchk("R7 never-enabled counter3", sa(3, 1), 0);

    // R3 two ports in one cycle
    pulse(2'b11, 4'd5, 16'h0011, 16'h0);
    e2 += 2;
    rchk("R3 two-port add", sa(2, 1), 32'(e2));

    // R6 freeze
    wr(8'h02, 32'h1);
    rchk("R6 freeze readback", 8'h02, 1);
    pulse(2'b11, 4'd5, 16'h0011, 16'h0);
    rchk("R6 frozen hold", sa(2, 1), 32'(e2));
    wr(8'h02, 32'h0);
    pulse(2'b01, 4'd5, 16'h0011, 16'h0);
    e2 += 1;
    rchk("R6 resumed", sa(2, 1), 32'(e2));

    // R7 disable keeps value
    wr(sa(2, 0), cfgw(4'd5, 16'h0011, 1'b0, 1'b0));
    pulse(2'b11, 4'd5, 16'h0011, 16'h0);
    rchk("R7 disabled hold", sa(2, 1), 32'(e2));

    // R8 value clear keeps config
    wr(8'h03, 32'h2);
    rchk("R8 value zero c0", sa(0, 1), 0);
    rchk("R8 value zero c2", sa(2, 1), 0);
    rchk("R8 config kept", sa(0, 0), cfgw(4'd3, 16'h00A5, 1'b1, 1'b0));
    pulse(2'b01, 4'd3, 16'h00A5, mk_attr(5'd7, 3'd1, 2'd0));
    rchk("R8 counts after clear", sa(0, 1), 1);
    // R8 config clear keeps value
    wr(8'h03, 32'h1);
    rchk("R8 config cleared", sa(0, 0), 0);
    rchk("R8 filter cleared", sa(0, 3), 0);
    rchk("R8 value kept", sa(0, 1), 1);

    // overflow: counter0 with interrupt, counter1 without
    wr(8'h03, 32'h2);
    wr(sa(0, 0), cfgw(4'd1, 16'h0001, 1'b1, 1'b1));
    wr(sa(1, 0), cfgw(4'd1, 16'h0001, 1'b1, 1'b0));
    stream(2047);
    rchk("R9 before wrap", sa(0, 1), 32'd4094);
    rchk("R9 no status yet", 8'h04, 0);
    @(negedge clk);
    set_ev(2'b11, 4'd1, 16'h0001, 16'h0);
    @(negedge clk);
    ev_valid = '0;
    chk("R11 irq one cycle later", 32'(irq), 0);
    @(negedge clk);
    chk("R11 irq raised", 32'(irq), 1);
    rchk("R9 status set", 8'h04, 32'h3);
    rchk("R9 wrapped value", sa(0, 1), 0);

    // R10 write-one-to-clear
    wr(8'h04, 32'h1);
    rchk("R10 cleared bit0 only", 8'h04, 32'h2);
    chk("R11 irq drops without enabled source", 32'(irq), 0);
    wr(8'h04, 32'h0);
    rchk("R10 zero write no effect", 8'h04, 32'h2);

    // R10 wrap wins over clear; set bit stays on repeat wrap
    stream(2047);
    @(negedge clk);
    set_ev(2'b11, 4'd1, 16'h0001, 16'h0);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1;
    @(negedge clk);
    ev_valid = '0; reg_wr = 1'b0;
    rchk("R10 wrap beats clear", 8'h04, 32'h3);
    chk("R11 irq after second wrap", 32'(irq), 1);
    wr(8'h04, 32'h3);
    rchk("R10 all cleared", 8'h04, 0);
    chk("R11 irq low", 32'(irq), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule